// File: doc/BRIEF.md
# Partition-Tagged Translation Buffer

This block is a small fully associative buffer that maps virtual page numbers to translation payloads. Each slot carries a virtual page number, a partition id, a context id, a flag that marks it as a real-address translation, a lock bit, a recently-used bit and a payload word. A translation request names a partition and either the real flag or a context id. One cycle later the block reports a hit with the slot index and payload, or a miss.

A second port carries management commands: inserting an entry, and five maintenance operations. These clear every slot, clear the unlocked slots of one partition, clear the slots of one partition/context pair, clear the slots that hold one page, or clear all used bits. A third port reads back the full tag word and the payload of any slot by index. Replacement follows a not-recently-used policy driven by the used bits. Slots that are locked are never chosen as victims.

Top module: `tlb_part`

## Requirements
- R1: A lookup with `lk_real`=1 hits a valid slot whose real flag is 1 and whose partition id and page number equal the request. The request's context id is ignored. A slot whose real flag is 0 never hits a real lookup.
- R2: A lookup with `lk_real`=0 hits a valid slot whose real flag is 0 and whose partition id, context id and page number all equal the request.
- R3: The page number is `va[63:13]`. Address bits 12..0 take no part in any comparison.
- R4: One cycle after `lk_en` is seen, exactly one of `lk_hit` and `lk_miss` is 1. On a hit, `lk_idx` and `lk_data` give the lowest-numbered matching slot and its payload. In a cycle after one without `lk_en`, both flags are 0.
- R5: Insert (`mg_op`=0) writes the lowest invalid slot. If every slot is valid, it writes the lowest unlocked slot whose used bit is 0. If there is none, it writes the lowest unlocked slot. If every slot is locked, the insert is dropped. The written slot takes `mg_lock` and has its used bit set.
- R6: A hit sets the used bit of the matching slot. When a hit or an insert leaves every valid unlocked slot with its used bit set, all those used bits are cleared except the bit of the slot just touched.
- R7: Invalidate-all (`mg_op`=1) clears every slot, locked ones included.
- R8: Demap-by-partition (`mg_op`=2) clears the valid slots whose partition id equals `mg_pid`, except locked slots.
- R9: Demap-by-context (`mg_op`=3) clears every slot whose partition id equals `mg_pid` and whose context id equals `mg_ctx`, whether locked or not.
- R10: Demap-by-page (`mg_op`=4) clears the slots that a lookup with the `mg_*` page, partition, real flag and context would hit.
- R11: Clear-used (`mg_op`=5) clears the used bit of every slot. Codes 6 and 7 change nothing.
- R12: One cycle after `rd_en`, `rd_valid` is 1, `rd_data` is the payload of slot `rd_idx`, and `rd_tag` holds that slot's fields: page number in bits 50..0, context 63..51, partition 66..64, real flag 67, used 68, lock 69, valid 70.
- R13: When `mg_en` and `lk_en` are both 1 in the same cycle, the command is carried out and the lookup reports a miss without touching any used bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_en | input | 1 | Lookup request |
| lk_va | input | 64 | Lookup virtual address |
| lk_pid | input | 3 | Lookup partition id |
| lk_ctx | input | 13 | Lookup context id |
| lk_real | input | 1 | Lookup is a real-address translation |
| mg_en | input | 1 | Management command valid |
| mg_op | input | 3 | Command code |
| mg_va | input | 64 | Command virtual address |
| mg_pid | input | 3 | Command partition id |
| mg_ctx | input | 13 | Command context id |
| mg_real | input | 1 | Command real flag |
| mg_lock | input | 1 | Lock bit for an inserted slot |
| mg_data | input | 32 | Payload for an inserted slot |
| rd_en | input | 1 | Diagnostic read request |
| rd_idx | input | 3 | Slot to read |
| lk_hit | output | 1 | Lookup hit |
| lk_miss | output | 1 | Lookup miss |
| lk_idx | output | 3 | Matching slot |
| lk_data | output | 32 | Payload of matching slot |
| rd_valid | output | 1 | Read data valid |
| rd_tag | output | 71 | Tag word of the read slot |
| rd_data | output | 32 | Payload of the read slot |

## Verification
The bench goes after the matching rules at their edges. A real lookup carries a context that differs from the stored one, and a non-real lookup hits a page held by a real slot. A design that compared context on real entries, or ignored the real flag, would hit or miss the wrong way. The demap tests mix locked and unlocked slots across two partitions, so a demap that ignored or over-applied the lock bit leaves behind, or removes, a visible entry. The replacement tests fill the buffer, force the used-bit rollover and check the next victim, fill it with locked slots so that an insert must be dropped, and send a lookup together with a command. A design that dropped the exception for the touched slot, or let that lookup through, returns a different slot or a hit.

// File: rtl/tlb_part_pkg.sv
package tlb_part_pkg;
  typedef enum logic [2:0] {
    OP_INSERT     = 3'd0,
    OP_INV_ALL    = 3'd1,
    OP_DEMAP_PID  = 3'd2,
    OP_DEMAP_CTX  = 3'd3,
    OP_DEMAP_PAGE = 3'd4,
    OP_CLR_USED   = 3'd5
  } mg_op_e;
endpackage

// File: rtl/tlb_part_first_one.sv
// Priority encoder: lowest set bit of a request vector.
module tlb_part_first_one #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_part_entry_cmp.sv
// Per-slot comparator against the lookup query and the command query.
module tlb_part_entry_cmp #(
  parameter int VPN_W = 51,
  parameter int PID_W = 3,
  parameter int CTX_W = 13
) (
  input  logic             e_valid,
  input  logic             e_real,
  input  logic [VPN_W-1:0] e_vpn,
  input  logic [PID_W-1:0] e_pid,
  input  logic [CTX_W-1:0] e_ctx,
  input  logic             q_real,
  input  logic [VPN_W-1:0] q_vpn,
  input  logic [PID_W-1:0] q_pid,
  input  logic [CTX_W-1:0] q_ctx,
  input  logic             m_real,
  input  logic [VPN_W-1:0] m_vpn,
  input  logic [PID_W-1:0] m_pid,
  input  logic [CTX_W-1:0] m_ctx,
  output logic             lk_match,
  output logic             pg_match,
  output logic             pid_match,
  output logic             ctx_match
);
  // Context only counts for virtual translations.
  assign lk_match  = e_valid && (e_pid == q_pid) && (e_vpn == q_vpn) &&
                     (e_real == q_real) && (q_real || (e_ctx == q_ctx));
  assign pg_match  = e_valid && (e_pid == m_pid) && (e_vpn == m_vpn) &&
                     (e_real == m_real) && (m_real || (e_ctx == m_ctx));
  assign pid_match = e_valid && (e_pid == m_pid);
  assign ctx_match = pid_match && (e_ctx == m_ctx);
endmodule

// File: rtl/tlb_part.sv
module tlb_part
  import tlb_part_pkg::*;
#(
  parameter int ENTRIES    = 8,
  parameter int VA_W       = 64,
  parameter int PAGE_SHIFT = 13,
  parameter int PID_W      = 3,
  parameter int CTX_W      = 13,
  parameter int DATA_W     = 32,
  localparam int VPN_W     = VA_W - PAGE_SHIFT,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int TAG_W     = VPN_W + CTX_W + PID_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_en,
  input  logic [VA_W-1:0]   lk_va,
  input  logic [PID_W-1:0]  lk_pid,
  input  logic [CTX_W-1:0]  lk_ctx,
  input  logic              lk_real,
  input  logic              mg_en,
  input  logic [2:0]        mg_op,
  input  logic [VA_W-1:0]   mg_va,
  input  logic [PID_W-1:0]  mg_pid,
  input  logic [CTX_W-1:0]  mg_ctx,
  input  logic              mg_real,
  input  logic              mg_lock,
  input  logic [DATA_W-1:0] mg_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [DATA_W-1:0] lk_data,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data
);
  // Slot state: control bits are reset, payload fields are not.
  logic [ENTRIES-1:0] v_q, lock_q, used_q, real_q;
  logic [ENTRIES-1:0] v_d, lock_d, used_d;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [PID_W-1:0]   pid_q  [ENTRIES];
  logic [CTX_W-1:0]   ctx_q  [ENTRIES];
  logic [DATA_W-1:0]  data_q [ENTRIES];

  logic [ENTRIES-1:0] lk_match, pg_match, pid_match, ctx_match;
  logic [VPN_W-1:0]   lk_vpn, mg_vpn;
  logic               unused_low;

  assign lk_vpn     = lk_va[VA_W-1:PAGE_SHIFT];
  assign mg_vpn     = mg_va[VA_W-1:PAGE_SHIFT];
  assign unused_low = ^{lk_va[PAGE_SHIFT-1:0], mg_va[PAGE_SHIFT-1:0]};

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    tlb_part_entry_cmp #(.VPN_W(VPN_W), .PID_W(PID_W), .CTX_W(CTX_W)) u_cmp (
      .e_valid  (v_q[g]),    .e_real (real_q[g]), .e_vpn (vpn_q[g]),
      .e_pid    (pid_q[g]),  .e_ctx  (ctx_q[g]),
      .q_real   (lk_real),   .q_vpn  (lk_vpn),    .q_pid (lk_pid), .q_ctx (lk_ctx),
      .m_real   (mg_real),   .m_vpn  (mg_vpn),    .m_pid (mg_pid), .m_ctx (mg_ctx),
      .lk_match (lk_match[g]), .pg_match (pg_match[g]),
      .pid_match(pid_match[g]), .ctx_match(ctx_match[g])
    );
  end

  // Hit and victim selection.
  logic             hit_found, free_found, nru_found, unl_found;
  logic [IDX_W-1:0] hit_idx, free_idx, nru_idx, unl_idx;

  tlb_part_first_one #(.N(ENTRIES), .IDX_W(IDX_W)) u_hit (
    .vec(lk_match), .found(hit_found), .idx(hit_idx));
  tlb_part_first_one #(.N(ENTRIES), .IDX_W(IDX_W)) u_free (
    .vec(~v_q), .found(free_found), .idx(free_idx));
  tlb_part_first_one #(.N(ENTRIES), .IDX_W(IDX_W)) u_nru (
    .vec(v_q & ~lock_q & ~used_q), .found(nru_found), .idx(nru_idx));
  tlb_part_first_one #(.N(ENTRIES), .IDX_W(IDX_W)) u_unl (
    .vec(~lock_q), .found(unl_found), .idx(unl_idx));

  // A command in the same cycle blocks the lookup.
  logic lk_go, lk_take;
  assign lk_go   = lk_en && !mg_en;
  assign lk_take = lk_go && hit_found;

  logic             wr_en, touch_en;
  logic [IDX_W-1:0] wr_sel, touch_idx;

  // Next-state for the slot control bits.
  always_comb begin
    v_d       = v_q;
    lock_d    = lock_q;
    used_d    = used_q;
    wr_en     = 1'b0;
    wr_sel    = free_idx;
    touch_en  = 1'b0;
    touch_idx = hit_idx;
    if (mg_en) begin
      case (mg_op_e'(mg_op))
        OP_INSERT: begin
          if (free_found) begin
            wr_en = 1'b1; wr_sel = free_idx;
          end else if (nru_found) begin
            wr_en = 1'b1; wr_sel = nru_idx;
          end else if (unl_found) begin
            wr_en = 1'b1; wr_sel = unl_idx;
          end
          if (wr_en) begin
            v_d[wr_sel]    = 1'b1;
            lock_d[wr_sel] = mg_lock;
            used_d[wr_sel] = 1'b1;
            touch_en       = 1'b1;
            touch_idx      = wr_sel;
          end
        end
        OP_INV_ALL:    v_d    = '0;
        OP_DEMAP_PID:  v_d    = v_q & ~(pid_match & ~lock_q);
        OP_DEMAP_CTX:  v_d    = v_q & ~ctx_match;
        OP_DEMAP_PAGE: v_d    = v_q & ~pg_match;
        OP_CLR_USED:   used_d = '0;
        default: ;
      endcase
    end else if (lk_take) begin
      used_d[hit_idx] = 1'b1;
      touch_en        = 1'b1;
      touch_idx       = hit_idx;
    end
    // Rollover once every valid unlocked slot is marked used.
    if (touch_en && (&(used_d | lock_d | ~v_d))) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (!lock_d[i] && (IDX_W'(i) != touch_idx)) used_d[i] = 1'b0;
      end
    end
  end

  logic              hit_q, miss_q, rd_valid_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] hit_data_q, rd_data_q;
  logic [TAG_W-1:0]  rd_tag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q        <= '0;
      lock_q     <= '0;
      used_q     <= '0;
      hit_q      <= 1'b0;
      miss_q     <= 1'b0;
      rd_valid_q <= 1'b0;
    end else begin
      v_q        <= v_d;
      lock_q     <= lock_d;
      used_q     <= used_d;
      hit_q      <= lk_take;
      miss_q     <= lk_en && !lk_take;
      rd_valid_q <= rd_en;
    end
  end

  // Payload fields, written only on insert.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      real_q[wr_sel] <= mg_real;
      vpn_q[wr_sel]  <= mg_vpn;
      pid_q[wr_sel]  <= mg_pid;
      ctx_q[wr_sel]  <= mg_ctx;
      data_q[wr_sel] <= mg_data;
    end
  end

  always_ff @(posedge clk) begin
    if (lk_take) begin
      idx_q      <= hit_idx;
      hit_data_q <= data_q[hit_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_tag_q  <= {v_q[rd_idx], lock_q[rd_idx], used_q[rd_idx], real_q[rd_idx],
                    pid_q[rd_idx], ctx_q[rd_idx], vpn_q[rd_idx]};
      rd_data_q <= data_q[rd_idx];
    end
  end

  assign lk_hit   = hit_q;
  assign lk_miss  = miss_q;
  assign lk_idx   = idx_q;
  assign lk_data  = hit_data_q;
  assign rd_valid = rd_valid_q;
  assign rd_tag   = rd_tag_q;
  assign rd_data  = rd_data_q;
endmodule

// File: rtl/tlb_part_checker.sv
module tlb_part_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       lk_en,
  input logic       mg_en,
  input logic [2:0] mg_op,
  input logic       rd_en,
  input logic       lk_hit,
  input logic       lk_miss,
  input logic       rd_valid
);
  AST_RESULT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_en |=> (lk_hit ^ lk_miss));  // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_en |=> (!lk_hit && !lk_miss));  // R4
  AST_CMD_BLOCKS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    (mg_en && lk_en) |=> (lk_miss && !lk_hit));  // R13
  AST_INVALL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (mg_en && mg_op == tlb_part_pkg::OP_INV_ALL) |=> (lk_en |=> !lk_hit));  // R7
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);  // R12
  AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);  // R12
endmodule

bind tlb_part tlb_part_checker u_chk (
  .clk(clk), .rst_n(rst_n), .lk_en(lk_en), .mg_en(mg_en), .mg_op(mg_op),
  .rd_en(rd_en), .lk_hit(lk_hit), .lk_miss(lk_miss), .rd_valid(rd_valid)
);

// File: tb/tlb_part_test.sv
`timescale 1ns/1ps
module tlb_part_test;
  localparam int VALID_B = 70, LOCK_B = 69, USED_B = 68, REAL_B = 67;
  localparam logic [2:0] C_INS = 3'd0, C_INV = 3'd1, C_DPID = 3'd2,
                         C_DCTX = 3'd3, C_DPG = 3'd4, C_CLRU = 3'd5;

  logic        clk, rst_n;
  logic        lk_en, lk_real, mg_en, mg_real, mg_lock, rd_en;
  logic [63:0] lk_va, mg_va;
  logic [2:0]  lk_pid, mg_pid, mg_op, rd_idx;
  logic [12:0] lk_ctx, mg_ctx;
  logic [31:0] mg_data;
  logic        lk_hit, lk_miss, rd_valid;
  logic [2:0]  lk_idx;
  logic [31:0] lk_data, rd_data;
  logic [70:0] rd_tag;

  int nchk = 0, nfail = 0;
  bit done = 0;

  tlb_part uut (
    .clk(clk), .rst_n(rst_n),
    .lk_en(lk_en), .lk_va(lk_va), .lk_pid(lk_pid), .lk_ctx(lk_ctx), .lk_real(lk_real),
    .mg_en(mg_en), .mg_op(mg_op), .mg_va(mg_va), .mg_pid(mg_pid), .mg_ctx(mg_ctx),
    .mg_real(mg_real), .mg_lock(mg_lock), .mg_data(mg_data),
    .rd_en(rd_en), .rd_idx(rd_idx),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_idx(lk_idx), .lk_data(lk_data),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [63:0] pg(input int vpn);
    return 64'(vpn) << 13;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    lk_en = 1'b0; mg_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic set_lk(input logic [63:0] va, input int pid, input int ctx, input bit rl);
    lk_en = 1'b1; lk_va = va; lk_pid = 3'(pid); lk_ctx = 13'(ctx); lk_real = rl;
  endtask

  task automatic set_mg(input logic [2:0] op, input logic [63:0] va, input int pid,
                        input int ctx, input bit rl, input bit lk, input logic [31:0] d);
    mg_en = 1'b1; mg_op = op; mg_va = va; mg_pid = 3'(pid); mg_ctx = 13'(ctx);
    mg_real = rl; mg_lock = lk; mg_data = d;
  endtask

  task automatic cmd(input logic [2:0] op, input logic [63:0] va, input int pid,
                     input int ctx, input bit rl, input bit lk, input logic [31:0] d);
    set_mg(op, va, pid, ctx, rl, lk, d);
    step();
  endtask

  task automatic ins(input int vpn, input int pid, input int ctx, input bit rl,
                     input bit lk, input logic [31:0] d);
    cmd(C_INS, pg(vpn), pid, ctx, rl, lk, d);
  endtask

  task automatic expect_lk(input string req, input logic [63:0] va, input int pid,
                           input int ctx, input bit rl, input bit hit,
                           input int idx, input logic [31:0] d);
    set_lk(va, pid, ctx, rl);
    step();
    chk({req, " hit"}, lk_hit, hit);
    chk({req, " miss"}, lk_miss, !hit);
    if (hit) begin
      chk({req, " idx"}, lk_idx, idx);
      chk({req, " data"}, lk_data, d);
    end
  endtask

  task automatic rb(input int idx, output logic [70:0] tag, output logic [31:0] d);
    rd_en = 1'b1; rd_idx = 3'(idx);
    step();
    chk("R12 rd_valid", rd_valid, 1'b1);
    tag = rd_tag; d = rd_data;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    lk_en = 0; mg_en = 0; rd_en = 0; lk_va = 0; mg_va = 0; lk_pid = 0; mg_pid = 0;
    lk_ctx = 0; mg_ctx = 0; lk_real = 0; mg_real = 0; mg_lock = 0; mg_data = 0;
    mg_op = 0; rd_idx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [70:0] t; logic [31:0] d;
    do_reset();
    chk("R4 reset hit", lk_hit, 1'b0);
    chk("R4 reset miss", lk_miss, 1'b0);
    chk("R12 reset rd_valid", rd_valid, 1'b0);
    rb(0, t, d);
    chk("R7 reset slot invalid", t[VALID_B], 1'b0);
    expect_lk("R4 empty lookup", pg(1), 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_match();
    logic [70:0] t; logic [31:0] d;
    do_reset();
    ins(10, 1, 5, 0, 0, 32'hA0);
    ins(20, 1, 7, 1, 0, 32'hB0);
    rb(1, t, d);
    chk("R12 tag word", t, {1'b1, 1'b0, 1'b1, 1'b1, 3'd1, 13'd7, 51'd20});
    chk("R12 payload", d, 32'hB0);
    rb(0, t, d);
    chk("R6 rollover spares touched only", t[USED_B], 1'b0);
    expect_lk("R3 R2 offset bits ignored", pg(10) | 64'h1abc, 1, 5, 0, 1, 0, 32'hA0);
    expect_lk("R2 wrong context", pg(10), 1, 6, 0, 0, 0, 0);
    expect_lk("R2 wrong partition", pg(10), 2, 5, 0, 0, 0, 0);
    expect_lk("R1 context ignored", pg(20) | 64'h0fff, 1, 99, 1, 1, 1, 32'hB0);
    expect_lk("R2 real slot vs virtual lookup", pg(20), 1, 7, 0, 0, 0, 0);
    expect_lk("R1 virtual slot vs real lookup", pg(10), 1, 5, 1, 0, 0, 0);
    step();
    chk("R4 idle hit", lk_hit, 1'b0);
    chk("R4 idle miss", lk_miss, 1'b0);
  endtask

  task automatic t_replace();
    logic [70:0] t; logic [31:0] d;
    do_reset();
    for (int i = 0; i < 8; i++) ins(100 + i, 0, 0, 0, 0, 32'(i));
    rb(5, t, d);
    chk("R5 fill order", t[50:0], 51'd105);
    rb(0, t, d);
    chk("R6 first slot rolled over", t[USED_B], 1'b0);
    rb(7, t, d);
    chk("R5 inserted slot used", t[USED_B], 1'b1);
    ins(200, 0, 0, 0, 0, 32'h200);
    rb(0, t, d);
    chk("R5 victim is unused slot", t[50:0], 51'd200);
    rb(3, t, d);
    chk("R6 rollover clears others", t[USED_B], 1'b0);
    rb(1, t, d);
    chk("R6 used clear before hit", t[USED_B], 1'b0);
    expect_lk("R6 hit slot 1", pg(101), 0, 0, 0, 1, 1, 32'd1);
    rb(1, t, d);
    chk("R6 hit sets used", t[USED_B], 1'b1);
    ins(201, 0, 0, 0, 0, 32'h201);
    expect_lk("R5 evicted page", pg(102), 0, 0, 0, 0, 0, 0);
    expect_lk("R5 next victim", pg(201), 0, 0, 0, 1, 2, 32'h201);
  endtask

  task automatic t_locked();
    do_reset();
    for (int i = 0; i < 7; i++) ins(300 + i, 0, 0, 0, 1, 32'(i));
    ins(500, 0, 0, 0, 0, 32'h55);
    expect_lk("R5 only unlocked slot", pg(500), 0, 0, 0, 1, 7, 32'h55);
    ins(501, 0, 0, 0, 0, 32'h66);
    expect_lk("R5 fallback evicts", pg(500), 0, 0, 0, 0, 0, 0);
    expect_lk("R5 fallback slot", pg(501), 0, 0, 0, 1, 7, 32'h66);
    expect_lk("R5 locked kept", pg(300), 0, 0, 0, 1, 0, 32'd0);
    do_reset();
    for (int i = 0; i < 8; i++) ins(300 + i, 0, 0, 0, 1, 32'(i));
    ins(600, 0, 0, 0, 0, 32'h77);
    expect_lk("R5 all locked drop", pg(600), 0, 0, 0, 0, 0, 0);
    expect_lk("R5 all locked intact", pg(307), 0, 0, 0, 1, 7, 32'd7);
  endtask

  task automatic t_demap();
    logic [70:0] t; logic [31:0] d;
    do_reset();
    ins(10, 1, 5, 0, 0, 32'h10);
    ins(11, 1, 5, 0, 1, 32'h11);
    ins(10, 2, 5, 0, 0, 32'h12);
    ins(10, 1, 6, 0, 0, 32'h13);
    ins(10, 1, 0, 1, 0, 32'h14);
    ins(12, 2, 9, 0, 1, 32'h15);
    cmd(C_DPG, pg(10), 1, 5, 0, 0, 0);
    expect_lk("R10 page gone", pg(10), 1, 5, 0, 0, 0, 0);
    expect_lk("R10 other ctx kept", pg(10), 1, 6, 0, 1, 3, 32'h13);
    expect_lk("R10 real kept", pg(10), 1, 0, 1, 1, 4, 32'h14);
    expect_lk("R10 other pid kept", pg(10), 2, 5, 0, 1, 2, 32'h12);
    cmd(C_DPG, pg(10), 1, 77, 1, 0, 0);
    expect_lk("R10 real page gone", pg(10), 1, 0, 1, 0, 0, 0);
    expect_lk("R10 virtual kept", pg(10), 1, 6, 0, 1, 3, 32'h13);
    cmd(C_DCTX, 64'd0, 1, 5, 0, 0, 0);
    expect_lk("R9 locked ctx gone", pg(11), 1, 5, 0, 0, 0, 0);
    expect_lk("R9 other ctx kept", pg(10), 1, 6, 0, 1, 3, 32'h13);
    cmd(C_DPID, 64'd0, 2, 0, 0, 0, 0);
    expect_lk("R8 unlocked gone", pg(10), 2, 5, 0, 0, 0, 0);
    expect_lk("R8 locked kept", pg(12), 2, 9, 0, 1, 5, 32'h15);
    expect_lk("R8 other pid kept", pg(10), 1, 6, 0, 1, 3, 32'h13);
    cmd(C_INV, 64'd0, 0, 0, 0, 0, 0);
    expect_lk("R7 locked gone", pg(12), 2, 9, 0, 0, 0, 0);
    expect_lk("R7 unlocked gone", pg(10), 1, 6, 0, 0, 0, 0);
    rb(5, t, d);
    chk("R7 valid bit", t[VALID_B], 1'b0);
  endtask

  task automatic t_priority();
    logic [70:0] t; logic [31:0] d;
    do_reset();
    ins(10, 0, 0, 0, 0, 32'h77);
    set_lk(pg(10), 0, 0, 0);
    set_mg(C_CLRU, 64'd0, 0, 0, 0, 0, 0);
    step();
    chk("R13 blocked hit", lk_hit, 1'b0);
    chk("R13 blocked miss", lk_miss, 1'b1);
    rb(0, t, d);
    chk("R11 used cleared", t[USED_B], 1'b0);
    chk("R11 still valid", t[VALID_B], 1'b1);
    expect_lk("R13 later lookup", pg(10), 0, 0, 0, 1, 0, 32'h77);
    rb(0, t, d);
    chk("R6 hit marks used", t[USED_B], 1'b1);
    set_lk(pg(10), 0, 0, 0);
    set_mg(3'd6, 64'd0, 0, 0, 0, 0, 0);
    step();
    chk("R13 nop still blocks", lk_miss, 1'b1);
    rb(0, t, d);
    chk("R11 code 6 no change", {t[VALID_B], t[LOCK_B], t[USED_B]}, 3'b101);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_match();
    t_replace();
    t_locked();
    t_demap();
    t_priority();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule